// File: doc/BRIEF.md
# Chip-Select-Latched Parallel Command Interface

This block is the slave end of a narrow parallel bus from a microcontroller. The bus has an active-low select, a read/write-not line, a mode line and four bidirectional data pins. A write word is turned into a drive request for five power outputs: four half-bridges (OUT1 to OUT4) and one high-side switch (OUT5). Each request is tristate, full source, full sink, or one of the current-limited load-test levels. The power stages themselves live elsewhere and take the drive codes from this block.

While the block is selected for writing, it follows the bus with no latch in the way. When the select is released, the last word is kept and stays in force. A release with every other line low puts the block into standby. A select held low for too long clears the stored word and also forces standby. During a read, the data pins turn around and carry a diagnostic nibble that another block supplies. All bus inputs pass through two-flop synchronizers onto the internal clock before any edge is detected.

Top module: `cmdif_top`

## Requirements
- R1: After reset every output drive is tristate, the data pins are not driven and standby is low. Drive codes: 0 tristate, 1 source, 2 sink, 3 source 140 mA, 4 sink 140 mA, 5 source 10 mA, 6 sink 10 mA. OUTk takes bits [3k-1:3k-3] of `drv_o`.
- R2: While select is low and read/write-not is low, a change of data or mode reaches the drives without any select edge (transparent write).
- R3: The rising edge of select keeps the last written word in force. While select is high, changes on data, mode and read/write-not have no effect.
- R4: With mode 0, codes 1/2 drive motor 1 (OUT1 source, OUT4 sink / OUT1 sink, OUT4 source). Codes 3/4 do the same with OUT2, and codes 5/6 with OUT3. All other outputs stay tristate.
- R5: With mode 0, code 7 (brake) sinks OUT1 to OUT4, and OUT5 is tristate.
- R6: With mode 0, code 8 turns on OUT5 as source, and only while OUT1 to OUT4 are all tristate.
- R7: With mode 0, code 15 (clear) and every code not listed above leave all outputs tristate.
- R8: With mode 1, the low three data bits select a load test, and data bit 3 is ignored. 3'b010 makes OUT4 a 140 mA source and 3'b001 makes it a 140 mA sink, each with no other output driven. 3'b110 makes OUT1 to OUT3 10 mA sinks, OUT4 a 140 mA source and OUT5 a 10 mA source. Any other value leaves all outputs tristate.
- R9: While select is low and read/write-not is high, the data pins are driven with the diagnostic nibble and the drives do not change. The pins are released after select returns high.
- R10: A rising edge of select with read/write-not, mode and data all low enters standby with all drives tristate. The next falling edge of select leaves standby.
- R11: Select held low for more than TIMEOUT_CYC synchronized cycles clears the stored word and enters standby, whatever the data lines carry. It also releases the data pins and blocks further writes until select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Bus select, active low |
| rwn_i | input | 1 | 1 = read, 0 = write |
| mode_i | input | 1 | 0 = drive command, 1 = load test |
| d_i | input | 4 | Data pins, input side |
| diag_i | input | 4 | Diagnostic nibble from the monitor block |
| d_o | output | 4 | Data pins, output side |
| d_oe_o | output | 1 | Output enable of the data pins |
| drv_o | output | 15 | Drive codes, 3 bits per output, OUT1 lowest |
| standby_o | output | 1 | Standby state |

## Verification
The bench holds select low past the timeout during both a read and a write. A design that does not gate writes after the timeout would revive the cleared command, and one that keeps the pins enabled would fight the bus in standby. It checks that a release with all lines low enters standby, while a release after a read does not. A design that ignored read/write-not in that test would drop a valid command. It also wiggles data and mode during a read and while deselected, which catches a decoder that stays transparent outside write cycles. It runs every motor code to catch an off-by-one in the pair mapping.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

    localparam int NUM_OUT  = 5;
    localparam int NUM_HB   = 4;
    localparam int DRV_BITS = 3;
    localparam int DATA_W   = 4;

    typedef enum logic [DRV_BITS-1:0] {
        DRV_HIZ     = 3'd0,
        DRV_SRC     = 3'd1,
        DRV_SNK     = 3'd2,
        DRV_SRC_140 = 3'd3,
        DRV_SNK_140 = 3'd4,
        DRV_SRC_10  = 3'd5,
        DRV_SNK_10  = 3'd6
    } drive_e;

    typedef drive_e [NUM_OUT-1:0] drv_vec_t;

    typedef struct packed {
        logic              mode;
        logic [DATA_W-1:0] data;
    } cmd_t;

    localparam logic [DATA_W-1:0] CODE_MOTOR_FIRST = 4'd1;
    localparam logic [DATA_W-1:0] CODE_MOTOR_LAST  = 4'd6;
    localparam logic [DATA_W-1:0] CODE_BRAKE       = 4'd7;
    localparam logic [DATA_W-1:0] CODE_HIGHSIDE    = 4'd8;
    localparam logic [2:0]        TST_OUT4_SRC     = 3'b010;
    localparam logic [2:0]        TST_OUT4_SNK     = 3'b001;
    localparam logic [2:0]        TST_ALL          = 3'b110;

    function automatic drv_vec_t decode_cmd(cmd_t c);
        drv_vec_t         v;
        logic [DATA_W-1:0] k;
        for (int i = 0; i < NUM_OUT; i++) v[i] = DRV_HIZ;
        k = c.data - CODE_MOTOR_FIRST;
        if (!c.mode) begin
            if (c.data >= CODE_MOTOR_FIRST && c.data <= CODE_MOTOR_LAST) begin
                // pair index in k[3:1], direction in k[0]
                v[k[3:1]]  = k[0] ? DRV_SNK : DRV_SRC;
                v[NUM_HB-1] = k[0] ? DRV_SRC : DRV_SNK;
            end else if (c.data == CODE_BRAKE) begin
                for (int i = 0; i < NUM_HB; i++) v[i] = DRV_SNK;
            end else if (c.data == CODE_HIGHSIDE) begin
                v[NUM_OUT-1] = DRV_SRC;
            end
        end else begin
            case (c.data[2:0])
                TST_OUT4_SRC: v[NUM_HB-1] = DRV_SRC_140;
                TST_OUT4_SNK: v[NUM_HB-1] = DRV_SNK_140;
                TST_ALL: begin
                    for (int i = 0; i < NUM_HB-1; i++) v[i] = DRV_SNK_10;
                    v[NUM_HB-1]  = DRV_SRC_140;
                    v[NUM_OUT-1] = DRV_SRC_10;
                end
                default: ;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/cmdif_sync.sv
module cmdif_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/cmdif_ctrl.sv
module cmdif_ctrl
    import cmdif_pkg::*;
#(
    parameter int TIMEOUT_CYC = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_s,
    input  logic              rwn_s,
    input  logic              mode_s,
    input  logic [DATA_W-1:0] d_s,
    output cmd_t              cmd_o,
    output logic              standby_o,
    output logic              timeout_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic          cs_q;
    logic [CW-1:0] cnt_q;
    cmd_t          cmd_q;
    logic          stby_q;
    logic          sel, rise, fall, expired, idle_word;

    assign sel       = ~csn_s;
    assign rise      = ~cs_q & csn_s;
    assign fall      = cs_q & ~csn_s;
    assign expired   = (cnt_q == CW'(TIMEOUT_CYC));
    assign idle_word = ~rwn_s & ~mode_s & (d_s == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            cnt_q  <= '0;
            cmd_q  <= '0;
            stby_q <= 1'b0;
        end else begin
            cs_q <= csn_s;
            if (csn_s)         cnt_q <= '0;
            else if (!expired) cnt_q <= cnt_q + CW'(1);

            if (expired) begin
                cmd_q  <= '0;
                stby_q <= 1'b1;
            end else begin
                if (fall) stby_q <= 1'b0;
                if (sel && !rwn_s) begin
                    cmd_q <= '{mode: mode_s, data: d_s};
                end else if (rise && idle_word) begin
                    cmd_q  <= '0;
                    stby_q <= 1'b1;
                end
            end
        end
    end

    assign cmd_o     = cmd_q;
    assign standby_o = stby_q;
    assign timeout_o = expired;

    // R11
    timeout_clear_chk: assert property (@(posedge clk) disable iff (rst)
        expired |=> (cmd_q == '0 && stby_q));

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(TIMEOUT_CYC));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sel) && $past(rwn_s) && !$past(expired)) |-> $stable(cmd_q));

    // R10
    standby_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && idle_word) |=> (stby_q && cmd_q == '0));
endmodule

// File: rtl/cmdif_decode.sv
module cmdif_decode
    import cmdif_pkg::*;
(
    input  cmd_t     cmd_i,
    input  logic     standby_i,
    output drv_vec_t drv_o
);
    drv_vec_t raw;

    always_comb begin
        raw = decode_cmd(cmd_i);
        if (standby_i) begin
            for (int i = 0; i < NUM_OUT; i++) raw[i] = DRV_HIZ;
        end
    end

    assign drv_o = raw;
endmodule

// File: rtl/cmdif_top.sv
module cmdif_top
    import cmdif_pkg::*;
#(
    parameter int TIMEOUT_CYC = 25
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          csn_i,
    input  logic                          rwn_i,
    input  logic                          mode_i,
    input  logic [DATA_W-1:0]             d_i,
    input  logic [DATA_W-1:0]             diag_i,
    output logic [DATA_W-1:0]             d_o,
    output logic                          d_oe_o,
    output logic [NUM_OUT*DRV_BITS-1:0]   drv_o,
    output logic                          standby_o
);
    localparam int BUS_W = DATA_W + 3;
    localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, {(BUS_W-1){1'b0}}};

    logic [BUS_W-1:0] bus_s;
    logic             csn_s, rwn_s, mode_s;
    logic [DATA_W-1:0] d_s;
    cmd_t             cmd;
    logic             stby, expired;
    drv_vec_t         drv;

    cmdif_sync #(.W(BUS_W), .RST_VAL(BUS_IDLE)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({csn_i, rwn_i, mode_i, d_i}),
        .sync_o  (bus_s)
    );

    assign {csn_s, rwn_s, mode_s, d_s} = bus_s;

    cmdif_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .csn_s     (csn_s),
        .rwn_s     (rwn_s),
        .mode_s    (mode_s),
        .d_s       (d_s),
        .cmd_o     (cmd),
        .standby_o (stby),
        .timeout_o (expired)
    );

    cmdif_decode i_decode (
        .cmd_i     (cmd),
        .standby_i (stby),
        .drv_o     (drv)
    );

    assign drv_o     = drv;
    assign standby_o = stby;
    assign d_o       = diag_i;
    assign d_oe_o    = ~csn_s & rwn_s & ~expired;

    // R6
    hs_interlock_chk: assert property (@(posedge clk) disable iff (rst)
        (drv[NUM_OUT-1] == DRV_SRC) |->
            (drv[0] == DRV_HIZ && drv[1] == DRV_HIZ && drv[2] == DRV_HIZ && drv[3] == DRV_HIZ));

    // R4
    one_motor_chk: assert property (@(posedge clk) disable iff (rst)
        (drv[NUM_HB-1] == DRV_SRC) |->
            $countones({drv[0] == DRV_SNK, drv[1] == DRV_SNK, drv[2] == DRV_SNK}) == 1);

    // R9
    bus_turn_chk: assert property (@(posedge clk) disable iff (rst)
        d_oe_o |-> (!$past(csn_i, 2) && $past(rwn_i, 2)));

    // R10
    standby_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        standby_o |-> (drv_o == '0));
endmodule

// File: tb/test_cmdif_top.sv
module test_cmdif_top;
    import cmdif_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csn = 1'b1, rwn = 1'b0, mode = 1'b0;
    logic [3:0]  d = 4'h0, diag = 4'h0;
    logic [3:0]  d_o;
    logic        d_oe;
    logic [14:0] drv;
    logic        stby;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdif_top #(.TIMEOUT_CYC(TMO)) i_cmdif_top (
        .clk(clk), .rst(rst), .csn_i(csn), .rwn_i(rwn), .mode_i(mode),
        .d_i(d), .diag_i(diag), .d_o(d_o), .d_oe_o(d_oe),
        .drv_o(drv), .standby_o(stby)
    );

    function automatic logic [14:0] pk(drive_e o1, drive_e o2, drive_e o3, drive_e o4, drive_e o5);
        return {o5, o4, o3, o2, o1};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        wait_cyc(4);
    endtask

    task automatic wr(logic m, logic [3:0] v);
        @(negedge clk);
        csn = 1'b0; rwn = 1'b0; mode = m; d = v;
        settle();
        csn = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk("R1 drv", drv, 15'd0);
        chk("R1 oe", d_oe, 0);
        chk("R1 standby", stby, 0);
        @(negedge clk); rst = 1'b0;
        settle();
        chk("R1 drv after release", drv, 15'd0);
    endtask

    task automatic t_transparent();
        @(negedge clk);
        csn = 1'b0; rwn = 1'b0; mode = 1'b0; d = 4'd1;
        settle();
        chk("R2 live M1", drv, pk(DRV_SRC, DRV_HIZ, DRV_HIZ, DRV_SNK, DRV_HIZ));
        d = 4'd4;
        settle();
        chk("R2 live M2 left", drv, pk(DRV_HIZ, DRV_SNK, DRV_HIZ, DRV_SRC, DRV_HIZ));
        csn = 1'b1;
        settle();
        chk("R3 held", drv, pk(DRV_HIZ, DRV_SNK, DRV_HIZ, DRV_SRC, DRV_HIZ));
        d = 4'd7; mode = 1'b1; rwn = 1'b1;
        settle();
        chk("R3 ignored while deselected", drv, pk(DRV_HIZ, DRV_SNK, DRV_HIZ, DRV_SRC, DRV_HIZ));
        chk("R3 pins idle", d_oe, 0);
    endtask

    task automatic t_motors();
        for (int k = 1; k <= 6; k++) begin
            logic [14:0] e;
            int pair = (k - 1) / 2;
            logic left = ((k - 1) % 2) == 1;
            drive_e hb = left ? DRV_SNK : DRV_SRC;
            drive_e o4 = left ? DRV_SRC : DRV_SNK;
            e = pk(pair == 0 ? hb : DRV_HIZ, pair == 1 ? hb : DRV_HIZ,
                   pair == 2 ? hb : DRV_HIZ, o4, DRV_HIZ);
            wr(1'b0, 4'(k));
            chk($sformatf("R4 code %0d", k), drv, e);
        end
    endtask

    task automatic t_brake_hs();
        wr(1'b0, 4'd7);
        chk("R5 brake", drv, pk(DRV_SNK, DRV_SNK, DRV_SNK, DRV_SNK, DRV_HIZ));
        wr(1'b0, 4'd8);
        chk("R6 high side", drv, pk(DRV_HIZ, DRV_HIZ, DRV_HIZ, DRV_HIZ, DRV_SRC));
    endtask

    task automatic t_undef_clear();
        wr(1'b0, 4'd9);
        chk("R7 undefined", drv, 15'd0);
        wr(1'b0, 4'd3);
        wr(1'b0, 4'd15);
        chk("R7 clear", drv, 15'd0);
        chk("R7 clear no standby", stby, 0);
    endtask

    task automatic t_loadtest();
        wr(1'b1, 4'b0010);
        chk("R8 out4 src", drv, pk(DRV_HIZ, DRV_HIZ, DRV_HIZ, DRV_SRC_140, DRV_HIZ));
        wr(1'b1, 4'b0001);
        chk("R8 out4 snk", drv, pk(DRV_HIZ, DRV_HIZ, DRV_HIZ, DRV_SNK_140, DRV_HIZ));
        wr(1'b1, 4'b0110);
        chk("R8 all", drv, pk(DRV_SNK_10, DRV_SNK_10, DRV_SNK_10, DRV_SRC_140, DRV_SRC_10));
        wr(1'b1, 4'b1110);
        chk("R8 bit3 ignored", drv, pk(DRV_SNK_10, DRV_SNK_10, DRV_SNK_10, DRV_SRC_140, DRV_SRC_10));
        wr(1'b1, 4'b0111);
        chk("R8 other", drv, 15'd0);
    endtask

    task automatic t_read();
        logic [14:0] m3 = pk(DRV_HIZ, DRV_HIZ, DRV_SRC, DRV_SNK, DRV_HIZ);
        wr(1'b0, 4'd5);
        @(negedge clk);
        diag = 4'hA; csn = 1'b0; rwn = 1'b1; mode = 1'b0; d = 4'd7;
        settle();
        chk("R9 oe", d_oe, 1);
        chk("R9 data", d_o, 4'hA);
        chk("R9 drive kept", drv, m3);
        d = 4'd8; mode = 1'b1;
        settle();
        chk("R9 drive kept after wiggle", drv, m3);
        csn = 1'b1;
        settle();
        chk("R9 released", d_oe, 0);
        chk("R9 drive after read", drv, m3);
        chk("R9 no standby", stby, 0);
    endtask

    task automatic t_standby();
        wr(1'b0, 4'd1);
        wr(1'b0, 4'd0);
        chk("R10 standby", stby, 1);
        chk("R10 hiz", drv, 15'd0);
        @(negedge clk);
        csn = 1'b0; rwn = 1'b1;
        settle();
        chk("R10 exit", stby, 0);
        csn = 1'b1;
        settle();
        chk("R10 read release no standby", stby, 0);
    endtask

    task automatic t_timeout();
        wr(1'b0, 4'd1);
        @(negedge clk);
        csn = 1'b0; rwn = 1'b1;
        wait_cyc(15);
        chk("R11 before limit oe", d_oe, 1);
        chk("R11 before limit drv", drv, pk(DRV_SRC, DRV_HIZ, DRV_HIZ, DRV_SNK, DRV_HIZ));
        wait_cyc(25);
        chk("R11 standby", stby, 1);
        chk("R11 cleared", drv, 15'd0);
        chk("R11 pins released", d_oe, 0);
        csn = 1'b1;
        settle();
        chk("R11 still standby", stby, 1);
        @(negedge clk);
        csn = 1'b0; rwn = 1'b0; mode = 1'b0; d = 4'd1;
        wait_cyc(40);
        chk("R11 write blocked", drv, 15'd0);
        csn = 1'b1;
        settle();
        chk("R11 no revive", drv, 15'd0);
        wr(1'b0, 4'd8);
        chk("R11 recovers", drv, pk(DRV_HIZ, DRV_HIZ, DRV_HIZ, DRV_HIZ, DRV_SRC));
        chk("R11 awake", stby, 0);
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_motors();
        t_brake_hs();
        t_undef_clear();
        t_loadtest();
        t_read();
        t_standby();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule